// File: doc/BRIEF.md
# Indirect Codec Control Register Bridge

This block lets a host bus reach a small bank of 8-bit codec control registers through two 32-bit words instead of one address per register. The host stores a command word that carries an internal register index, a data byte and a write-request flag. When that flag is set, the bridge captures the command, reports itself busy, and commits the byte to the bank a fixed number of cycles later. When the flag is clear, only the index and data fields are updated. The selected register is then streamed through a short fixed-latency pipeline into the low byte of the second host word.

The bank keeps its own power-on values and has two reserved slots that cannot be written. It also holds one status register whose two flags are set by pulses from the analog side and cleared by software. Setting either flag raises an interrupt bit in the read-data word, and reading that word clears the bit. Every register is also driven on a wide parallel output so that the surrounding control logic can use the settings directly.

Top module: `cdc_reg_bridge`

## Requirements
- R1: The command word sits at host offset 0x00 and reads back as bit 16 = busy, bits 14:8 = register index, bits 7:0 = data byte. Every other bit reads 0. The read-data word sits at offset 0x04.
- R2: Storing the command word with bit 16 set while idle starts a write. Bit 16 then reads 1 for exactly 4 cycles after the accepting edge. The target register takes the new byte on the same edge where bit 16 clears.
- R3: A command word stored while bit 16 reads 1 is ignored. Its index, data and write request all have no effect.
- R4: Storing the command word with bit 16 clear changes the index without writing. The selected register's value appears in bits 7:0 of the read-data word no more than 6 cycles later.
- R5: After reset, registers 0 to 27 hold 0c aa 78 00 00 ff 03 51 3f 00 00 04 04 04 04 04 04 0a 0a 00 00 00 c0 34 07 44 1f 00, in index order.
- R6: Registers 20 and 21 are reserved. Writes to them change nothing, and they always read 0.
- R7: A write to an index above 27 is dropped. Reading such an index returns 0 in the whole read-data word apart from bit 8.
- R8: Register 9 is status. A one-cycle pulse on ramp_up_done_i sets its bit 3, and a pulse on ramp_dn_done_i sets its bit 2. A software write stores the written byte, so writing 0 clears both flags. A pulse that arrives on the same edge as the write still leaves its flag set.
- R9: Bit 8 of the read-data word is an interrupt flag. Any status pulse sets it. A host read of offset 0x04 returns the flag and then clears it, unless a pulse arrives on that same edge.
- R10: ctrl_regs_o carries register i in bits 8*i+7:8*i for every index, and follows each committed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host store when selected |
| host_rd | input | 1 | Host load when selected (clears the interrupt on offset 0x04) |
| host_addr | input | HOST_AW | Host byte offset; bit 2 selects the word |
| host_wdata | input | 32 | Host store data |
| host_rdata | output | 32 | Word selected by host_addr |
| ramp_up_done_i | input | 1 | Pulse that sets status bit 3 |
| ramp_dn_done_i | input | 1 | Pulse that sets status bit 2 |
| ctrl_regs_o | output | 224 | All bank registers, register i in byte lane i |

## Verification
The hardest case to produce from the ports is a status pulse that lands on the very edge where a pending software write to register 9 commits. Only that case shows whether a hardware set takes priority over a software clear. The bench counts edges from the accepting store, holds the pulse high across the fourth edge, and then checks that the flag survived the written zero. A second hard case is a store issued while a write is still in flight. The bench issues it one cycle after the first store and then checks both the bank contents and the command word readback.

// File: rtl/cdc_bridge_pkg.sv
package cdc_bridge_pkg;

    localparam int REG_W      = 8;
    localparam int ADDR_W     = 7;
    localparam int NUM_REGS   = 28;
    localparam int WORD_W     = 32;
    localparam int STATUS_IDX = 9;
    localparam int RSV_LO     = 20;
    localparam int RSV_HI     = 21;
    localparam int UP_BIT     = 3;
    localparam int DN_BIT     = 2;
    localparam int BUSY_POS   = 16;
    localparam int IDX_LSB    = 8;
    localparam int IRQ_POS    = 8;
    localparam int BANK_W     = NUM_REGS * REG_W;

    typedef logic [REG_W-1:0]  reg_t;
    typedef logic [ADDR_W-1:0] idx_t;

    typedef struct packed {
        idx_t idx;
        reg_t data;
    } cmd_t;

    function automatic reg_t reset_value(input int idx);
        reg_t v;
        case (idx)
            0:  v = 8'h0c;  1:  v = 8'haa;  2:  v = 8'h78;  3:  v = 8'h00;
            4:  v = 8'h00;  5:  v = 8'hff;  6:  v = 8'h03;  7:  v = 8'h51;
            8:  v = 8'h3f;  9:  v = 8'h00;  10: v = 8'h00;  11: v = 8'h04;
            12: v = 8'h04;  13: v = 8'h04;  14: v = 8'h04;  15: v = 8'h04;
            16: v = 8'h04;  17: v = 8'h0a;  18: v = 8'h0a;  19: v = 8'h00;
            20: v = 8'h00;  21: v = 8'h00;  22: v = 8'hc0;  23: v = 8'h34;
            24: v = 8'h07;  25: v = 8'h44;  26: v = 8'h1f;  default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic in_bank(input idx_t a);
        return (int'(a) < NUM_REGS);
    endfunction

endpackage

// File: rtl/cdc_host_port.sv
module cdc_host_port
    import cdc_bridge_pkg::*;
#(
    parameter int WR_CYCLES = 4,
    parameter int HOST_AW   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_sel,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [HOST_AW-1:0]  host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    input  reg_t                rd_byte,
    input  logic                status_event,
    output idx_t                sel_idx,
    output logic                commit_en,
    output cmd_t                commit_cmd
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    cmd_t          cur_cmd;
    logic          busy;
    logic [CW-1:0] cnt;
    logic          irq;
    logic          cmd_store;
    logic          data_load;

    assign cmd_store = host_sel && host_wr && !host_addr[2];
    assign data_load = host_sel && host_rd &&  host_addr[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_cmd <= '0;
            busy    <= 1'b0;
            cnt     <= '0;
        end else if (cmd_store && !busy) begin
            cur_cmd <= '{idx: host_wdata[IDX_LSB +: ADDR_W], data: host_wdata[REG_W-1:0]};
            if (host_wdata[BUSY_POS]) begin
                busy <= 1'b1;
                cnt  <= CW'(WR_CYCLES);
            end
        end else if (busy) begin
            if (cnt == CW'(1)) begin
                busy <= 1'b0;
            end
            cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (status_event) begin
            irq <= 1'b1;
        end else if (data_load) begin
            irq <= 1'b0;
        end
    end

    assign commit_en  = busy && (cnt == CW'(1));
    assign commit_cmd = cur_cmd;
    assign sel_idx    = cur_cmd.idx;

    always_comb begin
        host_rdata = '0;
        if (host_addr[2]) begin
            host_rdata[REG_W-1:0] = rd_byte;
            host_rdata[IRQ_POS]   = irq;
        end else begin
            host_rdata[REG_W-1:0]              = cur_cmd.data;
            host_rdata[IDX_LSB +: ADDR_W]      = cur_cmd.idx;
            host_rdata[BUSY_POS]               = busy;
        end
    end

    // R2: an idle store with the request bit starts a busy period
    assert_busy_start_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_store && !busy && host_wdata[BUSY_POS]) |=> busy);

    // R3: stores during a busy period leave the captured command alone
    assert_store_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_store && busy) |=> $stable(cur_cmd));

    // R9: a load of the data word without a new event clears the flag
    assert_irq_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (data_load && !status_event) |=> !irq);

    // R9: an event always raises the flag
    assert_irq_set_R9: assert property (@(posedge clk) disable iff (rst)
        status_event |=> irq);

endmodule

// File: rtl/cdc_reg_bank.sv
module cdc_reg_bank
    import cdc_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit_en,
    input  cmd_t              commit_cmd,
    input  logic              ramp_up_done_i,
    input  logic              ramp_dn_done_i,
    input  idx_t              rd_idx,
    output reg_t              rd_val,
    output logic              status_event,
    output logic [BANK_W-1:0] bank_flat
);

    reg_t bank [NUM_REGS];

    assign status_event = ramp_up_done_i || ramp_dn_done_i;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        logic hit;
        assign hit = commit_en && (commit_cmd.idx == ADDR_W'(i));

        if (i == RSV_LO || i == RSV_HI) begin : g_rsv
            assign bank[i] = '0;
        end else if (i == STATUS_IDX) begin : g_status
            reg_t q;
            reg_t hw_set;
            always_comb begin
                hw_set         = '0;
                hw_set[UP_BIT] = ramp_up_done_i;
                hw_set[DN_BIT] = ramp_dn_done_i;
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= reset_value(i);
                end else if (hit) begin
                    q <= commit_cmd.data | hw_set;
                end else begin
                    q <= q | hw_set;
                end
            end
            assign bank[i] = q;
        end else begin : g_plain
            reg_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= reset_value(i);
                end else if (hit) begin
                    q <= commit_cmd.data;
                end
            end
            assign bank[i] = q;
        end

        assign bank_flat[i*REG_W +: REG_W] = bank[i];
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_idx == ADDR_W'(k)) begin
                rd_val = bank[k];
            end
        end
    end

    // R7: a commit outside the bank changes no register
    assert_oob_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (commit_en && !in_bank(commit_cmd.idx) && !status_event) |=> $stable(bank_flat));

    // R8: the ramp-up pulse leaves bit 3 of the status register set
    assert_up_set_R8: assert property (@(posedge clk) disable iff (rst)
        ramp_up_done_i |=> bank_flat[STATUS_IDX*REG_W + UP_BIT]);

    // R8: the ramp-down pulse leaves bit 2 of the status register set
    assert_dn_set_R8: assert property (@(posedge clk) disable iff (rst)
        ramp_dn_done_i |=> bank_flat[STATUS_IDX*REG_W + DN_BIT]);

    // R6: reserved slots never show a nonzero value
    assert_rsv_zero_R6: assert property (@(posedge clk) disable iff (rst)
        commit_en |=> (bank_flat[RSV_LO*REG_W +: REG_W] == '0 && bank_flat[RSV_HI*REG_W +: REG_W] == '0));

endmodule

// File: rtl/cdc_read_pipe.sv
module cdc_read_pipe
    import cdc_bridge_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  reg_t d,
    output reg_t q
);

    reg_t stage [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage[s] <= '0;
            end else if (s == 0) begin
                stage[s] <= d;
            end else begin
                stage[s] <= stage[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q = stage[LAT-1];

    // checker state: how long the input has held its value
    reg_t       last_d;
    logic [3:0] settle;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_d <= '0;
            settle <= '0;
        end else begin
            last_d <= d;
            if (d != last_d) begin
                settle <= '0;
            end else if (settle != 4'hf) begin
                settle <= settle + 4'd1;
            end
        end
    end

    // R4: once the input has been steady long enough, the output matches it
    assert_read_settle_R4: assert property (@(posedge clk) disable iff (rst)
        ((int'(settle) >= LAT - 1) && (d == last_d)) |-> (q == d));

endmodule

// File: rtl/cdc_reg_bridge.sv
module cdc_reg_bridge
    import cdc_bridge_pkg::*;
#(
    parameter int WR_CYCLES = 4,
    parameter int READ_LAT  = 3,
    parameter int HOST_AW   = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   host_sel,
    input  logic                   host_wr,
    input  logic                   host_rd,
    input  logic [HOST_AW-1:0]     host_addr,
    input  logic [31:0]            host_wdata,
    output logic [31:0]            host_rdata,
    input  logic                   ramp_up_done_i,
    input  logic                   ramp_dn_done_i,
    output logic [NUM_REGS*8-1:0]  ctrl_regs_o
);

    idx_t sel_idx;
    logic commit_en;
    cmd_t commit_cmd;
    reg_t lookup_val;
    reg_t piped_val;
    logic status_event;

    cdc_host_port #(
        .WR_CYCLES (WR_CYCLES),
        .HOST_AW   (HOST_AW)
    ) u_port (
        .clk          (clk),
        .rst          (rst),
        .host_sel     (host_sel),
        .host_wr      (host_wr),
        .host_rd      (host_rd),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .host_rdata   (host_rdata),
        .rd_byte      (piped_val),
        .status_event (status_event),
        .sel_idx      (sel_idx),
        .commit_en    (commit_en),
        .commit_cmd   (commit_cmd)
    );

    cdc_reg_bank u_bank (
        .clk            (clk),
        .rst            (rst),
        .commit_en      (commit_en),
        .commit_cmd     (commit_cmd),
        .ramp_up_done_i (ramp_up_done_i),
        .ramp_dn_done_i (ramp_dn_done_i),
        .rd_idx         (sel_idx),
        .rd_val         (lookup_val),
        .status_event   (status_event),
        .bank_flat      (ctrl_regs_o)
    );

    cdc_read_pipe #(
        .LAT (READ_LAT)
    ) u_pipe (
        .clk (clk),
        .rst (rst),
        .d   (lookup_val),
        .q   (piped_val)
    );

endmodule

// File: tb/tb_cdc_reg_bridge.sv
`timescale 1ns/1ps
module tb_cdc_reg_bridge;

    logic         clk = 1'b0;
    logic         rst;
    logic         host_sel, host_wr, host_rd;
    logic [3:0]   host_addr;
    logic [31:0]  host_wdata;
    logic [31:0]  host_rdata;
    logic         ramp_up_done_i, ramp_dn_done_i;
    logic [223:0] ctrl_regs_o;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    cdc_reg_bridge dut (
        .clk            (clk),
        .rst            (rst),
        .host_sel       (host_sel),
        .host_wr        (host_wr),
        .host_rd        (host_rd),
        .host_addr      (host_addr),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .ramp_up_done_i (ramp_up_done_i),
        .ramp_dn_done_i (ramp_dn_done_i),
        .ctrl_regs_o    (ctrl_regs_o)
    );

    function automatic logic [7:0] default_of(input int i);
        logic [7:0] t [28] = '{8'h0c, 8'haa, 8'h78, 8'h00, 8'h00, 8'hff, 8'h03, 8'h51,
                               8'h3f, 8'h00, 8'h00, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04,
                               8'h04, 8'h0a, 8'h0a, 8'h00, 8'h00, 8'h00, 8'hc0, 8'h34,
                               8'h07, 8'h44, 8'h1f, 8'h00};
        return t[i];
    endfunction

    // {index, written byte, expected read-back byte}
    localparam logic [22:0] VEC [0:7] = '{
        {7'd3,   8'h5a, 8'h5a},
        {7'd20,  8'hff, 8'h00},
        {7'd30,  8'h11, 8'h00},
        {7'd0,   8'ha5, 8'ha5},
        {7'd27,  8'h80, 8'h80},
        {7'd21,  8'h01, 8'h00},
        {7'd127, 8'hff, 8'h00},
        {7'd13,  8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [3:0] a, input logic [31:0] d);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0; host_addr = 4'h0;
    endtask

    task automatic wait_idle();
        host_addr = 4'h0;
        #1;
        while (host_rdata[16]) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic reg_write(input logic [6:0] idx, input logic [7:0] d);
        store(4'h0, {15'd0, 1'b1, 1'b0, idx, d});
        wait_idle();
    endtask

    task automatic reg_read(input logic [6:0] idx, output logic [31:0] word);
        store(4'h0, {15'd0, 1'b0, 1'b0, idx, 8'h00});
        repeat (6) @(negedge clk);
        host_addr = 4'h4;
        #1 word = host_rdata;
        host_addr = 4'h0;
    endtask

    task automatic load_data(output logic [31:0] word);
        host_sel = 1'b1; host_rd = 1'b1; host_addr = 4'h4;
        #1 word = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_sel = 1'b0; host_rd = 1'b0; host_addr = 4'h0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] w;
        rst = 1'b1; host_sel = 0; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
        ramp_up_done_i = 0; ramp_dn_done_i = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state: R1 command word, R5 and R10 defaults
        #1 check("R1 reset command word", host_rdata, 32'h0);
        for (int i = 0; i < 28; i++) begin
            check("R5 R10 default on parallel output", {24'd0, ctrl_regs_o[i*8 +: 8]}, {24'd0, default_of(i)});
        end
        for (int i = 0; i < 28; i += 3) begin
            reg_read(7'(i), w);
            check("R4 R5 default via host read", w, {24'd0, default_of(i)});
        end

        // Table walk: R2 writes, R6 reserved, R7 out of range, R4 read-back
        for (int v = 0; v < 8; v++) begin
            logic [6:0] idx;
            logic [7:0] wd, ex;
            {idx, wd, ex} = VEC[v];
            reg_write(idx, wd);
            reg_read(idx, w);
            check("R2 R4 R6 R7 table read-back", w, {24'd0, ex});
            if (idx < 7'd28) begin
                check("R10 R6 parallel output after write", {24'd0, ctrl_regs_o[idx*8 +: 8]}, {24'd0, ex});
            end
        end

        // R2: busy window length and commit edge
        store(4'h0, {15'd0, 1'b1, 1'b0, 7'd7, 8'h99});
        for (int k = 1; k <= 5; k++) begin
            host_addr = 4'h0;
            #1;
            check("R2 busy flag per cycle", {31'd0, host_rdata[16]}, {31'd0, k <= 4});
            check("R2 commit timing", {24'd0, ctrl_regs_o[7*8 +: 8]}, {24'd0, (k <= 4) ? 8'h51 : 8'h99});
            if (k == 1) check("R1 command word readback while busy", host_rdata, 32'h0001_0799);
            @(negedge clk);
        end

        // R3: store while busy is ignored
        store(4'h0, {15'd0, 1'b1, 1'b0, 7'd5, 8'h11});
        store(4'h0, {15'd0, 1'b1, 1'b0, 7'd6, 8'h22});
        wait_idle();
        check("R3 command word keeps first command", host_rdata, 32'h0000_0511);
        check("R3 first write landed", {24'd0, ctrl_regs_o[5*8 +: 8]}, 32'h11);
        check("R3 second write ignored", {24'd0, ctrl_regs_o[6*8 +: 8]}, 32'h03);

        // R1: unlisted bits read 0
        store(4'h0, 32'hfffe_ffff);
        #1 check("R1 unlisted command bits zero", host_rdata, 32'h0000_7fff);
        repeat (6) @(negedge clk);
        host_addr = 4'h4;
        #1 check("R7 out-of-range read word zero", host_rdata, 32'h0);
        host_addr = 4'h0;

        // R8 / R9: status flags and interrupt
        @(negedge clk);
        ramp_up_done_i = 1'b1;
        @(negedge clk);
        ramp_up_done_i = 1'b0;
        check("R8 ramp-up sets bit 3", {24'd0, ctrl_regs_o[9*8 +: 8]}, 32'h08);
        ramp_dn_done_i = 1'b1;
        @(negedge clk);
        ramp_dn_done_i = 1'b0;
        check("R8 ramp-down sets bit 2", {24'd0, ctrl_regs_o[9*8 +: 8]}, 32'h0c);
        load_data(w);
        check("R9 interrupt flag raised", {31'd0, w[8]}, 32'd1);
        load_data(w);
        check("R9 interrupt flag cleared by load", {31'd0, w[8]}, 32'd0);
        reg_read(7'd9, w);
        check("R8 R4 status via host read", w, 32'h0c);
        reg_write(7'd9, 8'h00);
        check("R8 software clears status", {24'd0, ctrl_regs_o[9*8 +: 8]}, 32'h00);

        // R8: pulse on the commit edge wins over the written zero
        store(4'h0, {15'd0, 1'b1, 1'b0, 7'd9, 8'h00});
        repeat (3) @(negedge clk);
        ramp_up_done_i = 1'b1;
        @(negedge clk);
        ramp_up_done_i = 1'b0;
        wait_idle();
        check("R8 hardware set wins at commit", {24'd0, ctrl_regs_o[9*8 +: 8]}, 32'h08);
        load_data(w);
        check("R9 interrupt after coincident pulse", {31'd0, w[8]}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule